// File: doc/BRIEF.md
# Two-Level Branch Direction and Target Predictor

This block sits in the fetch stage and proposes the next fetch address every cycle. Direction comes from a table of 2-bit saturating counters, addressed by a few word-address bits of the fetch PC joined with a short global history of recent branch outcomes, so one PC owns several counters and the recent path picks which of them is used. A small direct-mapped target buffer remembers where taken branches and jumps went. When the chosen counter says taken and the target buffer holds an entry tagged with exactly this fetch PC, fetch jumps to the stored target. In every other case it moves on to the sequential address, PC+4.

Nothing is learned at fetch time. When a branch or jump resolves later in the pipeline, the resolution port reports its PC, its real direction and its real target. That report trains the counter, pushes the outcome into the history, and fills or drops a target buffer entry. Decode, return-address prediction and pipeline flushing sit outside this block.

Top module: `twolvl_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken), the history is zero and every target buffer entry is invalid, so predTaken is 0 and predNextPc is fetchPc+4 for any fetchPc.
- R2: A taken resolution raises the addressed counter by one and stops at 3. A not-taken resolution lowers it by one and stops at 0.
- R3: The counter address is {history, fetchPc[IDX_W+1:2]}, with the history as the upper bits. Bits [1:0] of the PC have no effect on the counter used.
- R4: Each resolution shifts resTaken into bit 0 of the history, and older bits move up. The counter trained by a resolution is addressed with the history as it was before that shift, joined with resPc[IDX_W+1:2].
- R5: predTaken equals bit 1 of the selected counter, so the prediction is taken for counter values 2 and 3.
- R6: predNextPc equals the stored target when predTaken is 1 and the target buffer entry at fetchPc[BTB_W+1:2] is valid and its tag equals the full fetchPc. Otherwise predNextPc is fetchPc+4.
- R7: A taken resolution writes entry resPc[BTB_W+1:2] with valid set, tag resPc and target resTarget. It replaces whatever was stored there before.
- R8: A not-taken resolution invalidates entry resPc[BTB_W+1:2] only when that entry's tag equals resPc. An entry with a different tag is left unchanged.
- R9: While resIsBranch is 0, no counter, history bit or target buffer entry changes.
- R10: When a lookup and a resolution use the same counter or the same entry in the same cycle, the outputs in that cycle show the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | Address being fetched this cycle |
| resIsBranch | input | 1 | A branch or jump resolves this cycle |
| resPc | input | PC_W | Address of the resolving instruction |
| resTaken | input | 1 | Actual direction of the resolving instruction |
| resTarget | input | PC_W | Actual target of the resolving instruction |
| predNextPc | output | PC_W | Proposed next fetch address |
| predTaken | output | 1 | Direction predicted by the selected counter |

## Verification
The case hardest to reach from the ports is one particular counter holding one particular value while the history also holds the value that selects it. Every resolution moves the history, so training a counter also moves the index away from it. The stimulus works in two ways. Directed runs of same-direction resolutions first pin the history and then walk one counter to both saturation limits. A long pseudo-random sweep over a pool of 256 byte addresses then reaches every history value, target buffer aliasing between PCs that share an index, and cycles in which the fetch address and the resolving address coincide. Every cycle of both phases is compared against an arithmetic model of counters, history and buffer kept inside the bench.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Update strobes that the control half hands to the datapath each cycle.
  typedef struct packed {
    logic cntUp;      // raise the addressed counter (saturating)
    logic cntDown;    // lower the addressed counter (saturating)
    logic histShift;  // shift one outcome into the global history
    logic btbFill;    // write tag and target into the indexed entry
    logic btbDrop;    // invalidate the indexed entry if its tag matches
  } bpUpd_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic   resIsBranch,
  input  logic   resTaken,
  output bpUpd_t upd
);
  always_comb begin
    upd.cntUp     = resIsBranch &  resTaken;
    upd.cntDown   = resIsBranch & ~resTaken;
    upd.histShift = resIsBranch;
    upd.btbFill   = resIsBranch &  resTaken;
    upd.btbDrop   = resIsBranch & ~resTaken;
  end
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int BTB_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bpUpd_t          upd,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  output logic [PC_W-1:0] predNextPc,
  output logic            predTaken
);
  localparam int CIDX_W = HIST_W + IDX_W;
  localparam int CNT_N  = 1 << CIDX_W;
  localparam int BTB_N  = 1 << BTB_W;

  logic [1:0]        cntTab [CNT_N];
  logic [HIST_W-1:0] hist;
  logic              btbV   [BTB_N];
  logic [PC_W-1:0]   btbTag [BTB_N];
  logic [PC_W-1:0]   btbTgt [BTB_N];

  logic [CIDX_W-1:0] rdIdx, wrIdx;
  logic [BTB_W-1:0]  rdB, wrB;

  assign rdIdx = {hist, fetchPc[IDX_W+1:2]};
  assign wrIdx = {hist, resPc[IDX_W+1:2]};
  assign rdB   = fetchPc[BTB_W+1:2];
  assign wrB   = resPc[BTB_W+1:2];

  // Direction counters, one register pair per entry.
  for (genvar g = 0; g < CNT_N; g++) begin : gCnt
    logic sel;
    assign sel = (wrIdx == CIDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                                    cntTab[g] <= 2'b01;
      else if (sel && upd.cntUp   && cntTab[g] != 2'b11) cntTab[g] <= cntTab[g] + 2'b01;
      else if (sel && upd.cntDown && cntTab[g] != 2'b00) cntTab[g] <= cntTab[g] - 2'b01;
    end
  end

  // Global history: newest outcome enters at bit 0.
  always_ff @(posedge clk) begin
    if (!rst_n)              hist <= '0;
    else if (upd.histShift)  hist <= HIST_W'({hist, upd.cntUp});
  end

  // Direct-mapped target buffer.
  for (genvar b = 0; b < BTB_N; b++) begin : gBtb
    logic sel;
    assign sel = (wrB == BTB_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        btbV[b]   <= 1'b0;
        btbTag[b] <= '0;
        btbTgt[b] <= '0;
      end else if (sel && upd.btbFill) begin
        btbV[b]   <= 1'b1;
        btbTag[b] <= resPc;
        btbTgt[b] <= resTarget;
      end else if (sel && upd.btbDrop && btbTag[b] == resPc) begin
        btbV[b]   <= 1'b0;
      end
    end
  end

  // Lookup reads registered state, so same-cycle updates are not visible.
  logic [1:0] curCnt;
  logic       btbHit;
  always_comb begin
    curCnt     = cntTab[rdIdx];
    btbHit     = btbV[rdB] && (btbTag[rdB] == fetchPc);
    predTaken  = curCnt[1];
    predNextPc = (curCnt[1] && btbHit) ? btbTgt[rdB] : fetchPc + PC_W'(4);
  end
endmodule

// File: rtl/twolvl_predictor.sv
module twolvl_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int BTB_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            resIsBranch,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  output logic [PC_W-1:0] predNextPc,
  output logic            predTaken
);
  bpUpd_t upd;

  bp_ctrl u_ctrl (
    .resIsBranch (resIsBranch),
    .resTaken    (resTaken),
    .upd         (upd)
  );

  bp_datapath #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W),
    .BTB_W  (BTB_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (upd),
    .fetchPc    (fetchPc),
    .resPc      (resPc),
    .resTarget  (resTarget),
    .predNextPc (predNextPc),
    .predTaken  (predTaken)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetchPc,
  input logic            resIsBranch,
  input logic [PC_W-1:0] resPc,
  input logic            resTaken,
  input logic [PC_W-1:0] resTarget,
  input logic [PC_W-1:0] predNextPc,
  input logic            predTaken
);
  AST_FALLTHRU_NT: assert property (@(posedge clk) disable iff (!rst_n)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4)); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resIsBranch |=> (!$stable(fetchPc) || ($stable(predNextPc) && $stable(predTaken)))); // R9

  AST_FILL_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (resIsBranch && resTaken && resPc == fetchPc)
      |=> (!$stable(fetchPc) || !predTaken || predNextPc == $past(resTarget))); // R7

  AST_DROP_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (resIsBranch && !resTaken && resPc == fetchPc)
      |=> (!$stable(fetchPc) || predNextPc == fetchPc + PC_W'(4))); // R8
endmodule

bind twolvl_predictor bp_checker #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetchPc     (fetchPc),
  .resIsBranch (resIsBranch),
  .resPc       (resPc),
  .resTaken    (resTaken),
  .resTarget   (resTarget),
  .predNextPc  (predNextPc),
  .predTaken   (predTaken)
);

// File: tb/tb_twolvl_predictor.sv
module tb_twolvl_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, IDX_W = 4, HIST_W = 2, BTB_W = 3;
  localparam int CNT_N = 1 << (HIST_W + IDX_W);
  localparam int BTB_N = 1 << BTB_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] fetchPc = '0, resPc = '0, resTarget = '0;
  logic resIsBranch = 1'b0, resTaken = 1'b0;
  logic [PC_W-1:0] predNextPc;
  logic predTaken;

  int checks = 0, fails = 0;

  // Bench model of the predictor state.
  int cm [CNT_N];
  bit [HIST_W-1:0] gm;
  bit vm [BTB_N];
  logic [PC_W-1:0] tm [BTB_N], gtm [BTB_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  twolvl_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .BTB_W(BTB_W)) dut (
    .clk(clk), .rst_n(rst_n), .fetchPc(fetchPc), .resIsBranch(resIsBranch),
    .resPc(resPc), .resTaken(resTaken), .resTarget(resTarget),
    .predNextPc(predNextPc), .predTaken(predTaken));

  task automatic check(input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < CNT_N; i++) cm[i] = 1;
    gm = '0;
    for (int i = 0; i < BTB_N; i++) begin vm[i] = 0; tm[i] = '0; gtm[i] = '0; end
  endtask

  // One cycle: drive, check the lookup before the edge, then advance the model.
  task automatic step(input logic [PC_W-1:0] fpc, input bit rb, input logic [PC_W-1:0] rpc,
                      input bit rt, input logic [PC_W-1:0] rtg, input string tag);
    int ci, ui, bi;
    bit expT, hit;
    logic [PC_W-1:0] expN;
    @(negedge clk);
    fetchPc = fpc; resIsBranch = rb; resPc = rpc; resTaken = rt; resTarget = rtg;
    #1;
    ci   = int'({gm, fpc[IDX_W+1:2]});            // R3 index
    expT = (cm[ci] >= 2);                         // R5
    bi   = int'(fpc[BTB_W+1:2]);
    hit  = vm[bi] && (tm[bi] == fpc);
    expN = (expT && hit) ? gtm[bi] : fpc + 4;     // R6
    check({31'b0, predTaken}, {31'b0, expT}, {tag, " predTaken"});
    check(predNextPc, expN, {tag, " predNextPc"});
    @(posedge clk);
    if (rb) begin
      ui = int'({gm, rpc[IDX_W+1:2]});             // R4 pre-shift history
      if (rt) begin if (cm[ui] < 3) cm[ui]++; end  // R2
      else    begin if (cm[ui] > 0) cm[ui]--; end
      gm = HIST_W'({gm, rt});
      bi = int'(rpc[BTB_W+1:2]);
      if (rt) begin vm[bi] = 1; tm[bi] = rpc; gtm[bi] = rtg; end  // R7
      else if (vm[bi] && tm[bi] == rpc) vm[bi] = 0;               // R8
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit [31:0] lf;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state seen at every word and byte offset of a small window.
    for (int a = 0; a < 96; a++) step(32'(a), 0, '0, 0, '0, "R1 reset");

    // R7 R6 R3: train one taken branch, look it up at all byte offsets.
    for (int k = 0; k < 4; k++) step(32'h100, 1, 32'h40, 1, 32'h800, "R7 train");
    for (int o = 0; o < 4; o++) step(32'h40 + 32'(o), 0, '0, 0, '0, "R3 R6 lookup");

    // R8: not-taken at an aliasing PC leaves the entry; at the owner it drops it.
    step(32'h100, 1, 32'h60, 0, '0, "R8 alias");
    step(32'h40, 0, '0, 0, '0, "R8 kept");
    step(32'h100, 1, 32'h40, 0, '0, "R8 owner");
    step(32'h40, 0, '0, 0, '0, "R8 dropped");

    // R10: lookup and update of the same PC in one cycle.
    step(32'h40, 1, 32'h40, 1, 32'h900, "R10 same cycle");
    step(32'h40, 0, '0, 0, '0, "R10 after");

    // R2: walk one counter up to the top and back to the bottom.
    for (int k = 0; k < 6; k++) step(32'h24, 1, 32'h24, 1, 32'h500, "R2 saturate up");
    for (int k = 0; k < 6; k++) step(32'h24, 1, 32'h24, 0, '0, "R2 saturate down");

    // R4 R9 and the rest: pseudo-random sweep over a 256-byte address pool.
    lf = 32'h1234_5679;
    for (int n = 0; n < 6000; n++) begin
      logic [PC_W-1:0] rpc, fpc;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      rpc = 32'(lf[7:0]);
      fpc = lf[10] ? rpc : 32'(lf[18:11]);
      step(fpc, lf[20:19] != 2'b00, rpc, lf[21] | lf[22],
           32'h1000 + 32'(lf[30:23]) * 4, "R2 R4 R5 R6 R9 sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule